// File: doc/BRIEF.md
# Secure-Aware Interrupt Processor Interface

This block is the per-processor front end of an interrupt controller. A distributor, outside the block, presents the single highest-priority pending interrupt with its ID, 8-bit priority, security group and requesting CPU. The block decides whether that interrupt may reach the processor. It drives it out on a normal or a fast interrupt line, and runs the acknowledge and end-of-interrupt handshakes through a small register window.

Every bus access carries a secure qualifier. Acknowledge and completion behave differently for secure and non-secure callers. A nesting stack of active interrupts supplies the running priority, and a binary point splits priorities into a preemption group and a subpriority. The block reports each acknowledge and each completion to the distributor as a one-cycle pulse.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, control (0x100) and priority mask (0x104) read 0, running priority (0x114) reads 0xF0, identification (0x120) reads 0x3901043B, and irq_o and fiq_o are low.
- R2: An interrupt is signalled only when pend_valid_i is set, the enable for its group is set (control bit 0 for secure, bit 1 for non-secure), its priority is numerically below the mask (mask bits 7:3 at 0x104, low three bits zero), and it preempts the running priority.
- R3: When control bit 3 is set, an eligible secure interrupt drives fiq_o instead of irq_o. Non-secure interrupts always use irq_o.
- R4: A read of 0x10C that acknowledges returns the ID in bits 9:0 and, for IDs 0 to 15, the source CPU in bits 12:10 (0 otherwise). It pushes the interrupt onto the active stack, so 0x114 then reads its priority bits 7:4 with bits 3:0 zero, and it pulses ack_valid_o with ack_id_o in the following cycle.
- R5: A read of 0x10C with no eligible interrupt returns 1023 and changes no state.
- R6: A secure read of 0x10C while the eligible interrupt is non-secure returns 1022 and changes nothing if control bit 2 is 0. If bit 2 is 1, it returns the real ID and acknowledges.
- R7: A non-secure read of 0x10C while the eligible interrupt is secure returns 1023 and changes nothing.
- R8: A write to 0x110 (ID in bits 9:0, source CPU in bits 12:10, compared only for IDs 0 to 15) that matches the newest active entry pops it, restores the previous running priority and pulses eoi_valid_o with eoi_id_o. A write that does not match is ignored.
- R9: A secure write to 0x110 completing a non-secure interrupt is ignored when control bit 2 is 0 and honoured when it is 1. A non-secure write completing a secure interrupt is always ignored.
- R10: With binary point b, the group priority is the priority with bits b:0 cleared. A pending interrupt preempts an active one only if its group priority is strictly lower. Secure interrupts use the secure binary point (0x108, secure access), and non-secure ones use the non-secure binary point (0x11C secure access, or 0x108 non-secure access).
- R11: When control bit 4 is set, a non-secure read of 0x108 returns the secure binary point plus one, saturated at 7. Non-secure writes to 0x108 are then ignored, and non-secure interrupts preempt using that incremented value.
- R12: A read of 0x118 returns the same value a read of 0x10C would return at that time, but changes no state.
- R13: A non-secure access to control sees and writes only bit 1, and its other bits read as 0. Writes to the identification register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_valid_i | input | 1 | Distributor has a pending interrupt |
| pend_id_i | input | 10 | ID of the pending interrupt |
| pend_src_i | input | 3 | Requesting CPU for software interrupts |
| pend_prio_i | input | 8 | Priority, lower value is more urgent |
| pend_secure_i | input | 1 | Pending interrupt belongs to the secure group |
| bus_req_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_secure_i | input | 1 | Access is secure |
| bus_rdata_o | output | 32 | Read data, valid during a read access |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| ack_valid_o | output | 1 | Pulse: an interrupt was acknowledged |
| ack_id_o | output | 10 | ID of the acknowledged interrupt |
| eoi_valid_o | output | 1 | Pulse: an interrupt was completed |
| eoi_id_o | output | 10 | ID of the completed interrupt |

## Verification
Most faults in this block are faults in the active stack or the control bits, and they show up quickly at the ports. A stack that is pushed or popped wrongly appears in the next read of 0x114. From then on it also gates irq_o, so a sweep of pending priorities against one active priority flips the line at the wrong group boundary in that same cycle. A control bit latched from a wrong write appears in the response of the very next acknowledge or completion: 1022 or 1023 instead of a real ID, or a completion that leaves the running priority unchanged. The bench therefore reads back the running priority after every handshake and sweeps priorities against mask and binary point settings.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int ID_W    = 10;
  localparam int SRC_W   = 3;
  localparam int PRIO_W  = 8;
  localparam int CTRL_W  = 5;
  localparam int PMASK_W = 5;
  localparam int BP_W    = 3;
  localparam int SGI_LAST = 15;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_PMASK = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_BP    = 12'h108;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_EOI   = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_RUN   = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_HPEND = 12'h118;
  localparam logic [ADDR_W-1:0] OFS_BPNS  = 12'h11C;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 12'h120;

  localparam logic [ID_W-1:0] ID_NS_ONLY = 10'd1022;
  localparam logic [ID_W-1:0] ID_NONE    = 10'd1023;

  // control bit positions
  localparam int C_EN_S   = 0;
  localparam int C_EN_NS  = 1;
  localparam int C_ACKCTL = 2;
  localparam int C_FIQ    = 3;
  localparam int C_SHBP   = 4;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] prio;
    logic              secure;
  } act_entry_t;

  localparam act_entry_t ACT_IDLE = '{id: ID_NONE, src: '0, prio: '1, secure: 1'b0};

  function automatic logic [PRIO_W-1:0] group_prio(input logic [PRIO_W-1:0] p,
                                                   input logic [BP_W-1:0] bp);
    logic [PRIO_W-1:0] low;
    low = (PRIO_W'(2) << bp) - PRIO_W'(1);
    return p & ~low;
  endfunction
endpackage

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
  import irq_cpu_if_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  act_entry_t push_entry_i,
  output act_entry_t top_o,
  output logic       empty_o,
  output logic       full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  act_entry_t       ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign top_o   = empty_o ? ACT_IDLE : ent_q[top_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q[i] <= ACT_IDLE;
      else if (push_i && cnt_q == CNT_W'(i))    ent_q[i] <= push_entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - CNT_W'(1);
  end

  // R4
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R8
  no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/irq_fwd_gate.sv
module irq_fwd_gate
  import irq_cpu_if_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_valid_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic              pend_secure_i,
  input  logic              en_s_i,
  input  logic              en_ns_i,
  input  logic              fiq_en_i,
  input  logic [PRIO_W-1:0] pmask_i,
  input  logic [BP_W-1:0]   bp_s_i,
  input  logic [BP_W-1:0]   bp_ns_i,
  input  logic              act_empty_i,
  input  logic              act_full_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  output logic              eligible_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [BP_W-1:0]   bp_sel;
  logic [PRIO_W-1:0] grp_pend, grp_run;
  logic              preempt, grp_en;

  always_comb begin
    bp_sel     = pend_secure_i ? bp_s_i : bp_ns_i;
    grp_pend   = group_prio(pend_prio_i, bp_sel);
    grp_run    = group_prio(run_prio_i, bp_sel);
    preempt    = act_empty_i || (grp_pend < grp_run);
    grp_en     = pend_secure_i ? en_s_i : en_ns_i;
    eligible_o = pend_valid_i && grp_en && (pend_prio_i < pmask_i) && preempt && !act_full_i;
    fiq_o      = eligible_o && pend_secure_i && fiq_en_i;
    irq_o      = eligible_o && !fiq_o;
  end

  // R3
  fiq_secure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (pend_secure_i && fiq_en_i));
  // R2
  line_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || fiq_o) |-> pend_valid_i);
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int          STACK_DEPTH = 4,
  parameter logic [31:0] IDENT_VALUE = 32'h3901043B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_valid_i,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic [SRC_W-1:0]  pend_src_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic              pend_secure_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_secure_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              ack_valid_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_valid_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam int RUN_HI = 4;  // running priority reports the upper nibble
  localparam logic [BP_W-1:0] BP_MAX = '1;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [PMASK_W-1:0] pmask_q;
  logic [BP_W-1:0]    bp_s_q, bp_ns_q, bp_s_inc, bp_ns_eff;

  logic rd, wr;
  logic eligible;
  logic act_empty, act_full, push, pop;
  act_entry_t top, push_entry;

  logic [ID_W-1:0]  resp_id;
  logic [SRC_W-1:0] resp_src;
  logic             resp_take;

  logic [ID_W-1:0]  eoi_id;
  logic [SRC_W-1:0] eoi_src;
  logic             eoi_match, eoi_perm;

  assign rd = bus_req_i && !bus_we_i;
  assign wr = bus_req_i && bus_we_i;

  assign bp_s_inc  = (bp_s_q == BP_MAX) ? BP_MAX : bp_s_q + BP_W'(1);
  assign bp_ns_eff = ctrl_q[C_SHBP] ? bp_s_inc : bp_ns_q;

  irq_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_entry_i(push_entry),
    .top_o       (top),
    .empty_o     (act_empty),
    .full_o      (act_full)
  );

  irq_fwd_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_valid_i (pend_valid_i),
    .pend_prio_i  (pend_prio_i),
    .pend_secure_i(pend_secure_i),
    .en_s_i       (ctrl_q[C_EN_S]),
    .en_ns_i      (ctrl_q[C_EN_NS]),
    .fiq_en_i     (ctrl_q[C_FIQ]),
    .pmask_i      ({pmask_q, {(PRIO_W-PMASK_W){1'b0}}}),
    .bp_s_i       (bp_s_q),
    .bp_ns_i      (bp_ns_eff),
    .act_empty_i  (act_empty),
    .act_full_i   (act_full),
    .run_prio_i   (top.prio),
    .eligible_o   (eligible),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o)
  );

  // acknowledge / highest-pending response
  always_comb begin
    resp_id   = ID_NONE;
    resp_src  = '0;
    resp_take = 1'b0;
    if (eligible) begin
      if (pend_secure_i && !bus_secure_i) begin
        resp_id = ID_NONE;
      end else if (!pend_secure_i && bus_secure_i && !ctrl_q[C_ACKCTL]) begin
        resp_id = ID_NS_ONLY;
      end else begin
        resp_id   = pend_id_i;
        resp_src  = (pend_id_i <= ID_W'(SGI_LAST)) ? pend_src_i : '0;
        resp_take = 1'b1;
      end
    end
  end

  assign push = rd && (bus_addr_i == OFS_ACK) && resp_take;
  assign push_entry = '{id: pend_id_i, src: resp_src, prio: pend_prio_i, secure: pend_secure_i};

  // completion
  assign eoi_id  = bus_wdata_i[ID_W-1:0];
  assign eoi_src = bus_wdata_i[ID_W+SRC_W-1:ID_W];
  always_comb begin
    eoi_match = !act_empty && (top.id == eoi_id) &&
                ((top.id > ID_W'(SGI_LAST)) || (top.src == eoi_src));
    if (top.secure)         eoi_perm = bus_secure_i;
    else if (bus_secure_i)  eoi_perm = ctrl_q[C_ACKCTL];
    else                    eoi_perm = 1'b1;
  end
  assign pop = wr && (bus_addr_i == OFS_EOI) && eoi_match && eoi_perm;

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      pmask_q <= '0;
      bp_s_q  <= '0;
      bp_ns_q <= '0;
    end else if (wr) begin
      unique case (bus_addr_i)
        OFS_CTRL: begin
          if (bus_secure_i) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
          else              ctrl_q[C_EN_NS] <= bus_wdata_i[C_EN_NS];
        end
        OFS_PMASK: pmask_q <= bus_wdata_i[PRIO_W-1:PRIO_W-PMASK_W];
        OFS_BP: begin
          if (bus_secure_i)             bp_s_q  <= bus_wdata_i[BP_W-1:0];
          else if (!ctrl_q[C_SHBP])     bp_ns_q <= bus_wdata_i[BP_W-1:0];
        end
        OFS_BPNS: if (bus_secure_i) bp_ns_q <= bus_wdata_i[BP_W-1:0];
        default: ;
      endcase
    end
  end

  // handshake pulses toward the distributor
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_o <= 1'b0;
      ack_id_o    <= '0;
      eoi_valid_o <= 1'b0;
      eoi_id_o    <= '0;
    end else begin
      ack_valid_o <= push;
      eoi_valid_o <= pop;
      if (push) ack_id_o <= pend_id_i;
      if (pop)  eoi_id_o <= top.id;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (bus_addr_i)
        OFS_CTRL: begin
          if (bus_secure_i) bus_rdata_o[CTRL_W-1:0] = ctrl_q;
          else              bus_rdata_o[C_EN_NS]    = ctrl_q[C_EN_NS];
        end
        OFS_PMASK: bus_rdata_o[PRIO_W-1:PRIO_W-PMASK_W] = pmask_q;
        OFS_BP: begin
          if (bus_secure_i) bus_rdata_o[BP_W-1:0] = bp_s_q;
          else              bus_rdata_o[BP_W-1:0] = bp_ns_eff;
        end
        OFS_ACK, OFS_HPEND: bus_rdata_o[ID_W+SRC_W-1:0] = {resp_src, resp_id};
        OFS_RUN:  bus_rdata_o[PRIO_W-1:RUN_HI] = top.prio[PRIO_W-1:RUN_HI];
        OFS_BPNS: if (bus_secure_i) bus_rdata_o[BP_W-1:0] = bp_ns_q;
        OFS_IDENT: bus_rdata_o = IDENT_VALUE;
        default: ;
      endcase
    end
  end

  // R4
  ack_from_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(rd && bus_addr_i == OFS_ACK));
  // R4
  ack_pushes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> !act_empty);
  // R8
  eoi_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> $past(wr && bus_addr_i == OFS_EOI));
  // R13
  ctrl_ns_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !bus_secure_i && bus_addr_i == OFS_CTRL) |=>
      (ctrl_q[C_EN_S] == $past(ctrl_q[C_EN_S]) &&
       ctrl_q[CTRL_W-1:C_ACKCTL] == $past(ctrl_q[CTRL_W-1:C_ACKCTL])));
  // R12
  hpend_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i == OFS_HPEND) |-> !push);
endmodule

// File: tb/tb_irq_cpu_if.sv
module tb_irq_cpu_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pend_valid = 1'b0;
  logic [9:0]  pend_id = '0;
  logic [2:0]  pend_src = '0;
  logic [7:0]  pend_prio = '0;
  logic        pend_secure = 1'b0;
  logic        req = 1'b0, we = 1'b0, sec = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, ack_valid, eoi_valid;
  logic [9:0]  ack_id, eoi_id;

  int errors = 0, checks = 0;
  logic last_eoi;
  logic [9:0] last_eoi_id;

  always #10 clk = ~clk;

  irq_cpu_if dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pend_valid_i(pend_valid), .pend_id_i(pend_id), .pend_src_i(pend_src),
    .pend_prio_i(pend_prio), .pend_secure_i(pend_secure),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_secure_i(sec), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq),
    .ack_valid_o(ack_valid), .ack_id_o(ack_id),
    .eoi_valid_o(eoi_valid), .eoi_id_o(eoi_id)
  );

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d, input logic s);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; sec = s;
    @(posedge clk); #1;
    last_eoi = eoi_valid; last_eoi_id = eoi_id;
    req = 0; we = 0;
  endtask

  task automatic rd_reg(input logic [11:0] a, input logic s, output logic [31:0] d, output logic ackp);
    @(negedge clk); req = 1; we = 0; addr = a; sec = s;
    #1 d = rdata;
    @(posedge clk); #1;
    ackp = ack_valid;
    req = 0;
  endtask

  task automatic set_pend(input logic v, input int id, input int src, input int prio, input logic s);
    @(negedge clk);
    pend_valid = v; pend_id = 10'(id); pend_src = 3'(src); pend_prio = 8'(prio); pend_secure = s;
    #1;
  endtask

  function automatic int grp(input int p, input int bp);
    return p & ~((2 << bp) - 1) & 255;
  endfunction

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic ap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    #1 chk(!irq && !fiq, "R1 lines", {irq, fiq}, 0);
    rd_reg(12'h100, 1, d, ap); chk(d == 0, "R1 ctrl", d, 0);
    rd_reg(12'h104, 1, d, ap); chk(d == 0, "R1 mask", d, 0);
    rd_reg(12'h114, 1, d, ap); chk(d == 32'hF0, "R1 running", d, 32'hF0);
    rd_reg(12'h120, 0, d, ap); chk(d == 32'h3901043B, "R1 ident", d, 32'h3901043B);

    // R2 mask sweep, non-secure group enabled
    wr_reg(12'h100, 32'h3, 1);
    for (int m = 0; m < 32; m++) begin
      wr_reg(12'h104, 32'(m << 3), 0);
      for (int p = 0; p < 32; p++) begin
        set_pend(1, 40, 0, p << 3, 0);
        chk(irq == (p < m) && !fiq, "R2 mask", irq, (p < m));
      end
    end
    wr_reg(12'h100, 32'h1, 1);
    set_pend(1, 40, 0, 8, 0);
    chk(!irq, "R2 group disabled", irq, 0);
    wr_reg(12'h100, 32'h3, 1);

    // R3 fast line selection
    set_pend(1, 41, 0, 8'h10, 1);
    chk(irq && !fiq, "R3 secure on irq", {irq, fiq}, 2);
    wr_reg(12'h100, 32'hB, 1);
    chk(!irq && fiq, "R3 secure on fiq", {irq, fiq}, 1);
    set_pend(1, 42, 0, 8'h10, 0);
    chk(irq && !fiq, "R3 nonsecure on irq", {irq, fiq}, 2);
    wr_reg(12'h100, 32'h3, 1);

    // R4 acknowledge of a software interrupt
    set_pend(1, 5, 3, 8'h40, 0);
    rd_reg(12'h10C, 0, d, ap);
    chk(d == 32'hC05, "R4 ack value", d, 32'hC05);
    chk(ap && ack_id == 5, "R4 ack pulse", {ap, ack_id}, {1'b1, 10'd5});
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h40, "R4 running", d, 32'h40);
    chk(!irq, "R2 no self preempt", irq, 0);

    // R8 completion
    wr_reg(12'h110, 32'hC06, 0);
    chk(!last_eoi, "R8 mismatch pulse", last_eoi, 0);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h40, "R8 mismatch ignored", d, 32'h40);
    wr_reg(12'h110, 32'h405, 0);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h40, "R8 wrong source ignored", d, 32'h40);
    wr_reg(12'h110, 32'hC05, 0);
    chk(last_eoi && last_eoi_id == 5, "R8 eoi pulse", {last_eoi, last_eoi_id}, {1'b1, 10'd5});
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R8 running restored", d, 32'hF0);

    // R8 nesting restores previous level
    set_pend(1, 100, 0, 8'h80, 0);
    rd_reg(12'h10C, 0, d, ap); chk(d == 100, "R4 outer ack", d, 100);
    set_pend(1, 101, 0, 8'h20, 0);
    rd_reg(12'h10C, 0, d, ap); chk(d == 101, "R4 nested ack", d, 101);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h20, "R4 nested running", d, 32'h20);
    wr_reg(12'h110, 101, 0);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h80, "R8 nested restore", d, 32'h80);
    wr_reg(12'h110, 100, 0);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R8 outer restore", d, 32'hF0);

    // R5 nothing eligible
    set_pend(0, 7, 0, 8'h10, 0);
    rd_reg(12'h10C, 1, d, ap);
    chk(d == 1023 && !ap, "R5 none", d, 1023);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R5 no state", d, 32'hF0);

    // R6 secure ack of non-secure interrupt
    set_pend(1, 40, 0, 8'h40, 0);
    rd_reg(12'h10C, 1, d, ap);
    chk(d == 1022 && !ap, "R6 ackctl0", d, 1022);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R6 ackctl0 no state", d, 32'hF0);
    wr_reg(12'h100, 32'h7, 1);
    rd_reg(12'h10C, 1, d, ap);
    chk(d == 40 && ap, "R6 ackctl1", d, 40);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h40, "R6 ackctl1 active", d, 32'h40);

    // R9 secure completion of non-secure interrupt
    wr_reg(12'h100, 32'h3, 1);
    wr_reg(12'h110, 40, 1);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h40 && !last_eoi, "R9 ackctl0 ignored", d, 32'h40);
    wr_reg(12'h100, 32'h7, 1);
    wr_reg(12'h110, 40, 1);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R9 ackctl1 completes", d, 32'hF0);
    wr_reg(12'h100, 32'h3, 1);
    set_pend(1, 50, 0, 8'h20, 1);
    rd_reg(12'h10C, 1, d, ap); chk(d == 50, "R4 secure ack", d, 50);
    wr_reg(12'h110, 50, 0);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'h20, "R9 ns eoi of secure ignored", d, 32'h20);
    wr_reg(12'h110, 50, 1);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R9 secure eoi", d, 32'hF0);

    // R7 non-secure ack of secure interrupt
    set_pend(1, 51, 0, 8'h20, 1);
    rd_reg(12'h10C, 0, d, ap);
    chk(d == 1023 && !ap, "R7 hidden", d, 1023);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R7 no state", d, 32'hF0);

    // R12 highest pending has no side effect
    set_pend(1, 77, 0, 8'h30, 0);
    rd_reg(12'h118, 0, d, ap);
    chk(d == 77 && !ap, "R12 peek", d, 77);
    rd_reg(12'h114, 0, d, ap); chk(d == 32'hF0, "R12 no state", d, 32'hF0);
    rd_reg(12'h118, 1, d, ap); chk(d == 1022, "R12 secure peek", d, 1022);

    // R10 binary point sweep against active secure priority 0x44
    for (int bp = 0; bp < 8; bp++) begin
      wr_reg(12'h108, bp, 1);
      set_pend(1, 60, 0, 8'h44, 1);
      rd_reg(12'h10C, 1, d, ap); chk(d == 60, "R10 ack", d, 60);
      for (int p = 0; p < 248; p++) begin
        set_pend(1, 61, 0, p, 1);
        chk(irq == (grp(p, bp) < grp(8'h44, bp)), "R10 preempt", irq, (grp(p, bp) < grp(8'h44, bp)));
      end
      wr_reg(12'h110, 60, 1);
      chk(last_eoi, "R10 eoi", last_eoi, 1);
    end

    // R11 shared binary point
    wr_reg(12'h108, 2, 1);
    wr_reg(12'h11C, 0, 1);
    wr_reg(12'h100, 32'h13, 1);
    rd_reg(12'h108, 0, d, ap); chk(d == 3, "R11 ns read", d, 3);
    wr_reg(12'h108, 0, 0);
    rd_reg(12'h108, 0, d, ap); chk(d == 3, "R11 ns write ignored", d, 3);
    rd_reg(12'h11C, 1, d, ap); chk(d == 0, "R10 alias", d, 0);
    set_pend(1, 70, 0, 8'h44, 0);
    rd_reg(12'h10C, 0, d, ap); chk(d == 70, "R11 ack", d, 70);
    set_pend(1, 71, 0, 8'h41, 0);
    chk(!irq, "R11 shared point blocks", irq, 0);
    wr_reg(12'h100, 32'h3, 1);
    chk(irq, "R10 own ns point preempts", irq, 1);
    wr_reg(12'h110, 70, 0);
    wr_reg(12'h100, 32'h13, 1);
    wr_reg(12'h108, 7, 1);
    rd_reg(12'h108, 0, d, ap); chk(d == 7, "R11 saturate", d, 7);

    // R13 control protection and read-only identification
    wr_reg(12'h100, 32'h3, 1);
    wr_reg(12'h100, 32'h1D, 0);
    rd_reg(12'h100, 1, d, ap); chk(d == 32'h1, "R13 ns write", d, 32'h1);
    wr_reg(12'h100, 32'h1F, 0);
    rd_reg(12'h100, 0, d, ap); chk(d == 32'h2, "R13 ns read", d, 32'h2);
    rd_reg(12'h100, 1, d, ap); chk(d == 32'h3, "R13 secure read", d, 32'h3);
    wr_reg(12'h120, 32'h0, 1);
    rd_reg(12'h120, 1, d, ap); chk(d == 32'h3901043B, "R13 ident", d, 32'h3901043B);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule